// File: doc/BRIEF.md
# Register Access Unlock Sequencer

This block decides whether the host may reach a group of privileged address windows. It watches 32-bit writes to one key address, and that address is decoded in both states, so key writes are taken whether access is open or closed. A short key sequence opens access and a single fixed word closes it. The resulting state drives the access-enable input of the address decoder and of the interrupt logic.

The first of two magic words arms the sequencer. If the very next key write carries the second word, access opens, but only from the closed state. A zero word returns the sequencer to its idle step. The all-ones word closes access while it is open. Any other word, including a second word that does not match, returns the sequencer to idle and leaves the access state as it is.

A hard reset (asynchronous, active low) and a console reset (synchronous, active high) both force the closed state. Every entry into the closed state, including one caused by either reset, produces a one-cycle lock pulse that the interrupt logic uses to flush pending requests.

Top module: `key_gate_seq`

## Requirements
- R1: While `rst_n` is low, `unlocked` is 0 and `lock_pulse` is 1. `lock_pulse` falls at the first rising clock edge after `rst_n` is released.
- R2: When `con_rst` is sampled high, `unlocked` is 0 and `lock_pulse` is 1 for exactly the following cycle, whatever key write is presented in the same cycle.
- R3: A key write of 0x0000_0000 returns the sequencer to idle, so a following 0x4F43_4B5F does not open access.
- R4: A key write of 0x5F55_4E4C followed by a key write of 0x4F43_4B5F, with no other key write in between (cycles with `key_wr` low do not count), sets `unlocked` in the cycle after the second write, provided access was closed.
- R5: A key write of 0xFFFF_FFFF while `unlocked` is 1 clears `unlocked` in the next cycle and raises `lock_pulse` for that one cycle only.
- R6: A key write of 0xFFFF_FFFF while access is closed leaves `unlocked` at 0 and produces no `lock_pulse`.
- R7: A key write of any other value, or a second word that does not match, returns the sequencer to idle without changing `unlocked`. A lone 0x4F43_4B5F does not open access.
- R8: While access is open, the first word followed by the second word leaves `unlocked` at 1 and produces no pulse. Values on `key_data` while `key_wr` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| con_rst | input | 1 | Console reset, synchronous, active high |
| key_wr | input | 1 | Strobe for one write to the key address |
| key_data | input | 32 | Word written to the key address |
| unlocked | output | 1 | 1 while privileged windows are accessible |
| lock_pulse | output | 1 | One-cycle pulse on each entry into the closed state |

## Verification
A console reset and a key write can land in the same cycle, and the reset must take priority. The bench provokes this twice. First it arms the sequencer, then presents the second key word in the same cycle as a console reset; access must stay closed and exactly one lock pulse must appear. Then, with access open, it presents the lock word in the same cycle as a console reset; this must give one closed state and a single one-cycle pulse, not two.

// File: rtl/key_gate_seq.sv
module key_gate_seq #(
  parameter int          DW         = 32,
  parameter logic [31:0] KEY_FIRST  = 32'h5F55_4E4C,
  parameter logic [31:0] KEY_SECOND = 32'h4F43_4B5F,
  parameter logic [31:0] KEY_LOCK   = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          con_rst,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic          unlocked,
  output logic          lock_pulse
);

  localparam logic [DW-1:0] K1 = DW'(KEY_FIRST);
  localparam logic [DW-1:0] K2 = DW'(KEY_SECOND);
  localparam logic [DW-1:0] KL = DW'(KEY_LOCK);

  logic armed, unl_q, pulse_q;
  logic hit_first, hit_second, hit_lock;

  assign hit_first  = key_data == K1;
  assign hit_second = key_data == K2;
  assign hit_lock   = key_data == KL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q   <= 1'b0;
      armed   <= 1'b0;
      pulse_q <= 1'b1;
    end else if (con_rst) begin
      unl_q   <= 1'b0;
      armed   <= 1'b0;
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
      if (key_wr) begin
        armed <= hit_first;
        if (hit_second && armed && !unl_q) unl_q <= 1'b1;
        if (hit_lock && unl_q) begin
          unl_q   <= 1'b0;
          pulse_q <= 1'b1;
        end
      end
    end
  end

  assign unlocked   = unl_q;
  assign lock_pulse = pulse_q;

  p_open_needs_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && hit_second && armed && !con_rst));

  p_con_rst_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    con_rst |=> (!unlocked && lock_pulse));

  p_close_pulses_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> lock_pulse);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_pulse && !con_rst && !(key_wr && hit_lock && unlocked)) |=> !lock_pulse);

  p_lock_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_wr && hit_lock && !con_rst) |=> !unlocked);

  p_zero_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == '0) |=> !armed);

  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_wr && !con_rst) |=> $stable(unlocked));

endmodule

// File: tb/key_gate_seq_tb.sv
module key_gate_seq_tb;
  localparam logic [31:0] K1 = 32'h5F55_4E4C;
  localparam logic [31:0] K2 = 32'h4F43_4B5F;
  localparam logic [31:0] KL = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0, con_rst = 0, key_wr = 0;
  logic [31:0] key_data = '0;
  logic unlocked, lock_pulse;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  key_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .con_rst(con_rst), .key_wr(key_wr),
    .key_data(key_data), .unlocked(unlocked), .lock_pulse(lock_pulse));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); key_wr = 1; key_data = d;
    @(negedge clk); key_wr = 0; key_data = '0;
  endtask

  task automatic crst();
    @(negedge clk); con_rst = 1;
    @(negedge clk); con_rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 unlocked in reset", unlocked, 0);
    chk("R1 pulse in reset", lock_pulse, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pulse after first edge", lock_pulse, 0);
    chk("R1 still locked", unlocked, 0);
  endtask

  task automatic t_unlock();
    wr(K1);
    @(negedge clk); @(negedge clk);
    wr(K2);
    chk("R4 unlocked after sequence", unlocked, 1);
    chk("R4 no pulse on open", lock_pulse, 0);
  endtask

  task automatic t_lock();
    wr(KL);
    chk("R5 locked", unlocked, 0);
    chk("R5 pulse", lock_pulse, 1);
    @(negedge clk);
    chk("R5 pulse one cycle", lock_pulse, 0);
  endtask

  task automatic t_lock_when_locked();
    wr(KL);
    chk("R6 stays locked", unlocked, 0);
    chk("R6 no pulse", lock_pulse, 0);
  endtask

  task automatic t_zero();
    wr(K1); wr(32'h0); wr(K2);
    chk("R3 zero idles step", unlocked, 0);
  endtask

  task automatic t_other();
    wr(K1); wr(32'h1234_5678); wr(K2);
    chk("R7 other value idles", unlocked, 0);
    wr(K2);
    chk("R7 lone second word", unlocked, 0);
    wr(K1); wr(K1); wr(K2);
    chk("R7 mismatch second idles then re-arm", unlocked, 1);
    wr(32'hDEAD_BEEF);
    chk("R7 other value keeps open", unlocked, 1);
  endtask

  task automatic t_unlocked_seq();
    wr(K1); wr(K2);
    chk("R8 seq while open stays open", unlocked, 1);
    chk("R8 seq while open no pulse", lock_pulse, 0);
    @(negedge clk); key_data = KL;
    @(negedge clk); key_data = '0;
    chk("R8 data without strobe ignored", unlocked, 1);
  endtask

  task automatic t_con_rst();
    crst();
    chk("R2 console reset locks", unlocked, 0);
    @(negedge clk);
    key_data = '0;
  endtask

  task automatic t_collide();
    wr(K1);
    @(negedge clk); key_wr = 1; key_data = K2; con_rst = 1;
    @(negedge clk); key_wr = 0; key_data = '0; con_rst = 0;
    chk("R2 reset beats second key", unlocked, 0);
    chk("R2 reset pulse", lock_pulse, 1);
    @(negedge clk);
    chk("R2 pulse one cycle", lock_pulse, 0);
    wr(K1); wr(K2);
    chk("R4 reopen", unlocked, 1);
    @(negedge clk); key_wr = 1; key_data = KL; con_rst = 1;
    @(negedge clk); key_wr = 0; key_data = '0; con_rst = 0;
    chk("R2 reset with lock word locks", unlocked, 0);
    chk("R2 reset with lock word pulse", lock_pulse, 1);
    @(negedge clk);
    chk("R2 single pulse", lock_pulse, 0);
  endtask

  initial begin
    t_reset();
    t_unlock();
    t_lock();
    t_lock_when_locked();
    t_zero();
    t_other();
    t_unlocked_seq();
    t_con_rst();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule